// File: doc/BRIEF.md
# GPIO port with per-pin interrupt detection

A 32-pin general-purpose I/O port controlled through a small word-addressed register interface. Software sets, per pin, an output value and a direction; an output pin drives its data bit onto the pad and asserts the pin's output enable. Every pad is brought into the clock domain by a two-flop synchroniser, and the synchronised levels can be read back at any time.

Each pin has an interrupt detector. A 2-bit trigger code selects low level, high level, rising edge or falling edge, and a separate per-pin edge-select bit makes the pin trigger on any transition, overriding the code. Detected events set a sticky status bit that software clears by writing ones. A status bit raises an interrupt request only if its mask bit is set. Two request lines are provided: one for the lower half of the pins and one for the upper half.

The register port is a plain single-cycle access: a write takes effect at the clock edge where `bus_req` and `bus_we` are high, and read data appears on `bus_rdata` from the edge where a read request is sampled and holds until the next read.

Top module: `gpio_irq_port`

## Requirements
- R1: Register word index (byte offset = 4 x index): 0 output data, 1 direction, 2 synchronised pad levels (read only), 3 trigger codes for pins 0-15, 4 trigger codes for pins 16-31, 5 interrupt mask, 6 interrupt status, 7 edge select. Bit n of each per-pin register belongs to pin n. All writable registers reset to zero, so after reset `pad_oe`, `pad_out` and `irq` are 0.
- R2: A direction bit of 1 makes `pad_oe[n]` 1 and the pin drives `pad_out[n]` from data bit n; a direction bit of 0 leaves the pin an input (`pad_oe[n]` = 0).
- R3: Reading index 2 returns the pad levels after a two-flop synchroniser; a pad change is visible in that register from the second rising edge after it.
- R4: Pin n < 16 takes its trigger code from bits [2n+1:2n] of index 3; pin n >= 16 from bits [2(n-16)+1:2(n-16)] of index 4. Code 0 sets status while the synchronised level is low, 1 while high, 2 on a 0-to-1 change, 3 on a 1-to-0 change, where a change compares the synchronised value with its value one cycle earlier.
- R5: When edge-select bit n is 1, pin n sets status on both rising and falling changes and its trigger code has no effect.
- R6: Writing a 1 to a status bit clears it; writing 0 leaves the bit unchanged.
- R7: A level condition sets its status bit on every cycle it holds, so a clear while the level persists leaves the bit at 1; an event in the same cycle as a clear wins.
- R8: `irq[0]` is 1 exactly when some pin in 0-15 has both status and mask bits 1; `irq[1]` likewise for pins 16-31. Status is set even for masked pins.
- R9: Every register reads back through `bus_rdata` the value last stored in it (index 6 returns the live status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 2 | Interrupt requests for pins 0-15 and 16-31 |

## Verification
The assertions take for granted that `pad_in` levels are held long enough to pass the synchroniser and that the bus signals are known whenever the clock is running out of reset. The stimulus changes pads and bus signals only on the falling clock edge and holds every pad level for at least four cycles before the status is read, so each event is seen once by the detector. Pads start low and stay low until reset is released, so no spurious edge is produced by the synchroniser's reset value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_DIR  = 3'd1;
  localparam logic [2:0] IDX_PAD  = 3'd2;
  localparam logic [2:0] IDX_CFGL = 3'd3;
  localparam logic [2:0] IDX_CFGH = 3'd4;
  localparam logic [2:0] IDX_MASK = 3'd5;
  localparam logic [2:0] IDX_STAT = 3'd6;
  localparam logic [2:0] IDX_EDGE = 3'd7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic [1:0] trig_i,
  input  logic       any_edge_i,
  output logic       event_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    if (any_edge_i) begin
      event_o = rise | fall;
    end else begin
      unique case (trig_e'(trig_i))
        TRIG_LOW:  event_o = ~level_i;
        TRIG_HIGH: event_o = level_i;
        TRIG_RISE: event_o = rise;
        TRIG_FALL: event_o = fall;
        default:   event_o = 1'b0;
      endcase
    end
  end

  // R5: with any-edge select an event means the level just moved
  p_any_edge_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_edge_i && event_o) |-> (level_i != $past(level_i)));

  // R4: a rising-edge trigger fires only when the level is now high
  p_rise_is_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_edge_i && trig_i == 2'd2 && event_o) |-> (level_i && !$past(level_i)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [1:0]      irq
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] data_q, dir_q, mask_q, stat_q, edge_q;
  logic [PINS-1:0] cfg_lo_q, cfg_hi_q;
  logic [PINS-1:0] pad_sync, evt, clr, stat_d, masked;
  logic [2*PINS-1:0] cfg_all;
  logic            wr, rd;

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pad_sync)
  );

  assign cfg_all = {cfg_hi_q, cfg_lo_q};

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    gpio_pin_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (pad_sync[n]),
      .trig_i    (cfg_all[2*n +: 2]),
      .any_edge_i(edge_q[n]),
      .event_o   (evt[n])
    );
  end

  assign wr     = bus_req & bus_we;
  assign rd     = bus_req & ~bus_we;
  assign clr    = (wr && bus_addr == IDX_STAT) ? bus_wdata : '0;
  assign stat_d = (stat_q & ~clr) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      edge_q   <= '0;
      stat_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr) begin
        unique case (bus_addr)
          IDX_DATA: data_q   <= bus_wdata;
          IDX_DIR:  dir_q    <= bus_wdata;
          IDX_CFGL: cfg_lo_q <= bus_wdata;
          IDX_CFGH: cfg_hi_q <= bus_wdata;
          IDX_MASK: mask_q   <= bus_wdata;
          IDX_EDGE: edge_q   <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd) begin
      unique case (bus_addr)
        IDX_DATA: bus_rdata <= data_q;
        IDX_DIR:  bus_rdata <= dir_q;
        IDX_PAD:  bus_rdata <= pad_sync;
        IDX_CFGL: bus_rdata <= cfg_lo_q;
        IDX_CFGH: bus_rdata <= cfg_hi_q;
        IDX_MASK: bus_rdata <= mask_q;
        IDX_STAT: bus_rdata <= stat_q;
        IDX_EDGE: bus_rdata <= edge_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign masked  = stat_q & mask_q;
  assign irq[0]  = |masked[HALF-1:0];
  assign irq[1]  = |masked[PINS-1:HALF];
  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  // R6: a cleared bit with no event that cycle is zero afterwards
  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr & ~evt)) == '0));

  // R6: bits not written with 1 stay set
  p_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr)));

  // R7: an event always lands in status, clear or not
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

  // R8: a request line needs at least one mask bit in its half
  p_irq_lo_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (mask_q[HALF-1:0] != '0));
  p_irq_hi_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> (mask_q[PINS-1:HALF] != '0));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic [1:0]  irq;

  int tests = 0, fails = 0;
  logic [31:0] cfg_lo_sh = '0, cfg_hi_sh = '0, edge_sh = '0;

  always #4 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {pin[4:0], code[1:0], any_edge, start, end, expect}
  localparam int NV = 11;
  localparam logic [10:0] VEC [NV] = '{
    {5'd0,  2'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd1,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd2,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd3,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd17, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd18, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd20, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd31, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd5,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd16, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd15, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {30'd0, irq}, 32'h0);
    rd(3'd5, r); chk("R1 mask reset", r, 32'h0);

    // R2 / R9 output path
    wr(3'd0, 32'hA5A5_0F0F);
    wr(3'd1, 32'hFF00_00FF);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFF00_00FF);
    rd(3'd1, r); chk("R9 dir readback", r, 32'hFF00_00FF);
    rd(3'd0, r); chk("R9 data readback", r, 32'hA5A5_0F0F);

    // R3 synchroniser latency: visible from second edge
    @(negedge clk); pad_in = 32'h8000_0001;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 3'd2;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R3 not yet through sync", bus_rdata, 32'h0);
    rd(3'd2, r); chk("R3 pad levels", r, 32'h8000_0001);
    pad_in = '0;
    idle(4);

    // R4 R5 R8 vector table
    for (int i = 0; i < NV; i++) begin
      logic [4:0] pin;
      logic [1:0] code;
      logic es, st, en, ex;
      {pin, code, es, st, en, ex} = VEC[i];
      pad_in[pin] = st;
      idle(4);
      if (pin < 16) begin
        cfg_lo_sh[2*pin +: 2] = code;
        wr(3'd3, cfg_lo_sh);
      end else begin
        cfg_hi_sh[2*(pin-16) +: 2] = code;
        wr(3'd4, cfg_hi_sh);
      end
      edge_sh[pin] = es;
      wr(3'd7, edge_sh);
      wr(3'd5, 32'h1 << pin);
      wr(3'd6, 32'h1 << pin);
      rd(3'd6, r); chk("R6 cleared before event", {31'd0, r[pin]}, 32'h0);
      chk("R8 irq idle", {31'd0, irq[pin >= 16]}, 32'h0);
      pad_in[pin] = en;
      idle(4);
      rd(3'd6, r);
      chk(es ? "R5 any-edge status" : "R4 trigger status", {31'd0, r[pin]}, {31'd0, ex});
      chk("R8 irq line", {31'd0, irq[pin >= 16]}, {31'd0, ex});
      chk("R8 other irq line", {31'd0, irq[pin < 16]}, 32'h0);
    end

    // R9 config readback
    rd(3'd3, r); chk("R9 cfg low readback", r, cfg_lo_sh);
    rd(3'd4, r); chk("R9 cfg high readback", r, cfg_hi_sh);

    // R6 writing zero keeps status; pin 15 set by last row
    wr(3'd6, 32'h0);
    rd(3'd6, r); chk("R6 zero write keeps", {31'd0, r[15]}, 32'h1);
    wr(3'd6, 32'h0000_8000);
    rd(3'd6, r); chk("R6 w1c clears", {31'd0, r[15]}, 32'h0);

    // R7 level persists: pin 6 code 0 with pad low
    wr(3'd5, 32'h0000_0040);
    wr(3'd6, 32'h0000_0040);
    rd(3'd6, r); chk("R7 level re-sets status", {31'd0, r[6]}, 32'h1);
    chk("R7 irq stays", {30'd0, irq}, 32'h1);
    wr(3'd5, 32'h0);
    chk("R8 masked off", {30'd0, irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule